// File: doc/BRIEF.md
# Tamper-Driven Security State Monitor

This block is an always-on security monitor. It keeps a small security state machine, collects violation events from a bank of external tamper pins, three digital sensor alarms and a rollover-protected monotonic counter, and releases two master keys only while the state is trusted. The keys are a fused one-time key, which arrives as an input, and a zeroizable key, which is held in a register inside the block.

The tamper bank has two modes, chosen by a configuration input. In passive mode, every pin is compared against a configured level through a glitch filter of programmable length. In active mode, the lower half of the pins drive pseudo-random patterns from an LFSR. The upper half take those patterns back as returns, so a cut or shorted mesh shows up as a mismatch. Any violation forces a one-way move into a fail state. The fail state cuts off both keys, clears the zeroizable key and raises a zeroize flag. Only a power-on reset leaves it.

Top module: `tamper_state_monitor`

## Requirements
- R1: After reset the state reads 0 (INIT), and key_valid, zeroize, the counter, both key outputs and tamper_oe are all zero.
- R2: The state encoding is INIT=0, TRUSTED=1, SECURE=2, NON_SECURE=3, FAIL=4. In INIT, boot_done moves the state to TRUSTED when boot_pass is high and to NON_SECURE when it is low. In TRUSTED, lock_secure moves the state to SECURE. In TRUSTED or SECURE, drop_trust moves the state to NON_SECURE.
- R3: key_valid is high only in TRUSTED or SECURE. In that case otp_key_o equals otp_key and zmk_key_o equals the zeroizable key register. In every other state both key outputs are zero.
- R4: A violation seen at a clock edge puts the state in FAIL at that edge, whatever the state was. FAIL ignores every request and is left only by reset. zeroize is high exactly while the state is FAIL.
- R5: Each of sens_temp, sens_volt and sens_freq is on its own a violation source.
- R6: In passive mode (cfg_active=0), pin i mismatches when tamper_in[i] differs from cfg_pol[i]. If a mismatch is sampled on cfg_filt+1 consecutive edges, it is a violation at the last of those edges. A mismatch sampled on only cfg_filt consecutive edges is not a violation. A cfg_filt of 0 makes any single mismatch a violation.
- R7: In active mode (cfg_active=1), tamper_oe is high on pins 0 to 4 and low on pins 5 to 9. tamper_out[k] (k=0..4) carries a changing LFSR bit pattern, and its return is tamper_in[k+5]. If a return differs from its driven bit on one edge only, there is no effect. If it differs on two consecutive edges, that is a violation. tamper_in[4:0] is ignored in this mode.
- R8: The monotonic counter mc_value increments by one at each edge with mc_inc high and holds its value otherwise.
- R9: The counter saturates at all ones. Reaching all ones is a violation, so the state is FAIL one edge after the counter reaches that value.
- R10: zmk_load with zmk_din writes the zeroizable key register, which is visible on zmk_key_o while key_valid is high. A violation clears the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_active | input | 1 | 1 = active meshes, 0 = passive pins |
| cfg_pol | input | NPINS | Expected level of each passive pin |
| cfg_filt | input | FILT_W | Passive glitch filter length |
| tamper_in | input | NPINS | Tamper pin inputs |
| tamper_out | output | NPINS | Mesh drive values (lower half in active mode) |
| tamper_oe | output | NPINS | Output enable for each tamper pin |
| sens_temp | input | 1 | Temperature alarm |
| sens_volt | input | 1 | Voltage alarm |
| sens_freq | input | 1 | Frequency alarm |
| boot_done | input | 1 | Boot check finished |
| boot_pass | input | 1 | Boot check result |
| lock_secure | input | 1 | Request TRUSTED to SECURE |
| drop_trust | input | 1 | Request move to NON_SECURE |
| mc_inc | input | 1 | Monotonic counter increment request |
| mc_value | output | CTR_W | Monotonic counter value |
| otp_key | input | KEY_W | Fused one-time key |
| zmk_load | input | 1 | Write strobe for the zeroizable key |
| zmk_din | input | KEY_W | Zeroizable key write data |
| otp_key_o | output | KEY_W | Gated fused key |
| zmk_key_o | output | KEY_W | Gated zeroizable key |
| sec_state | output | 3 | Current security state |
| key_valid | output | 1 | Keys released |
| zeroize | output | 1 | Fail state / zeroization flag |

## Verification
The violation path is tried in four ways, each on a fresh trusted state: a passive pin held mismatched, an active mesh return flipped, a sensor pulse and a counter driven to all ones. For the filtered sources, the bench holds the fault for exactly one edge fewer than the threshold and then exactly for the threshold. This separates an off-by-one in the glitch filter or in the two-sample mesh rule from a correct one. The active run also keeps the ignored lower pins mismatched, which shows that the passive filters are gated off in that mode. A violation while still in INIT, and requests sent while in FAIL, show that the move to FAIL is one-way and happens from any state.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_TRUSTED = 3'd1,
    ST_SECURE  = 3'd2,
    ST_NONSEC  = 3'd3,
    ST_FAIL    = 3'd4
  } sec_state_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Fibonacci LFSR, taps 16,14,13,11
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic keys_open(input sec_state_e s);
    return (s == ST_TRUSTED) || (s == ST_SECURE);
  endfunction

endpackage

// File: rtl/tsm_passive_filt.sv
module tsm_passive_filt #(
  parameter int unsigned FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pin,
  input  logic              pol,
  input  logic [FILT_W-1:0] limit,
  output logic              hit
);
  localparam int unsigned CW = FILT_W + 1;

  logic [CW-1:0] run_q;
  logic          mism;

  assign mism = en && (pin != pol);
  // violation on the edge where the run already spans 'limit' earlier edges
  assign hit  = mism && (run_q >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!mism)        run_q <= '0;
    else if (run_q != '1)  run_q <= run_q + CW'(1);
  end
endmodule

// File: rtl/tsm_mesh.sv
module tsm_mesh
  import tsm_pkg::*;
#(
  parameter int unsigned NMESH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NMESH-1:0] ret,
  output logic [NMESH-1:0] drive,
  output logic [NMESH-1:0] hit
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [NMESH-1:0]  miss_q;
  logic [NMESH-1:0]  exp_bits;
  logic [NMESH-1:0]  miss;

  assign exp_bits = lfsr_q[NMESH-1:0];
  assign miss     = en ? (ret ^ exp_bits) : '0;
  assign drive    = en ? exp_bits : '0;
  assign hit      = miss & miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      miss_q <= '0;
    end else begin
      miss_q <= miss;
      if (en) lfsr_q <= lfsr_step(lfsr_q);
    end
  end
endmodule

// File: rtl/tsm_mono_ctr.sv
module tsm_mono_ctr #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         at_max
);
  logic [W-1:0] cnt_q;

  assign value  = cnt_q;
  assign at_max = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (inc && !at_max) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/tamper_state_monitor.sv
module tamper_state_monitor
  import tsm_pkg::*;
#(
  parameter int unsigned NPINS  = 10,
  parameter int unsigned FILT_W = 4,
  parameter int unsigned CTR_W  = 48,
  parameter int unsigned KEY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_active,
  input  logic [NPINS-1:0]  cfg_pol,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic [NPINS-1:0]  tamper_in,
  output logic [NPINS-1:0]  tamper_out,
  output logic [NPINS-1:0]  tamper_oe,
  input  logic              sens_temp,
  input  logic              sens_volt,
  input  logic              sens_freq,
  input  logic              boot_done,
  input  logic              boot_pass,
  input  logic              lock_secure,
  input  logic              drop_trust,
  input  logic              mc_inc,
  output logic [CTR_W-1:0]  mc_value,
  input  logic [KEY_W-1:0]  otp_key,
  input  logic              zmk_load,
  input  logic [KEY_W-1:0]  zmk_din,
  output logic [KEY_W-1:0]  otp_key_o,
  output logic [KEY_W-1:0]  zmk_key_o,
  output logic [2:0]        sec_state,
  output logic              key_valid,
  output logic              zeroize
);
  localparam int unsigned NMESH = NPINS / 2;

  // named internal events
  logic [NPINS-1:0] pas_hit;
  logic [NMESH-1:0] mesh_hit;
  logic [NMESH-1:0] mesh_drive;
  logic             tamper_hit;
  logic             sensor_hit;
  logic             roll_hit;
  logic             viol_any;

  sec_state_e       state_q, state_d;
  logic [KEY_W-1:0] zmk_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pas
    tsm_passive_filt #(.FILT_W(FILT_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!cfg_active),
      .pin   (tamper_in[i]),
      .pol   (cfg_pol[i]),
      .limit (cfg_filt),
      .hit   (pas_hit[i])
    );
  end

  tsm_mesh #(.NMESH(NMESH)) u_mesh (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg_active),
    .ret   (tamper_in[NMESH +: NMESH]),
    .drive (mesh_drive),
    .hit   (mesh_hit)
  );

  tsm_mono_ctr #(.W(CTR_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (mc_inc),
    .value  (mc_value),
    .at_max (roll_hit)
  );

  assign tamper_out = NPINS'(mesh_drive);
  assign tamper_oe  = cfg_active ? NPINS'({NMESH{1'b1}}) : '0;

  assign tamper_hit = (|pas_hit) || (|mesh_hit);
  assign sensor_hit = sens_temp || sens_volt || sens_freq;
  assign viol_any   = tamper_hit || sensor_hit || roll_hit;

  always_comb begin
    state_d = state_q;
    if (viol_any) state_d = ST_FAIL;
    else begin
      unique case (state_q)
        ST_INIT:    if (boot_done) state_d = boot_pass ? ST_TRUSTED : ST_NONSEC;
        ST_TRUSTED: if (drop_trust) state_d = ST_NONSEC;
                    else if (lock_secure) state_d = ST_SECURE;
        ST_SECURE:  if (drop_trust) state_d = ST_NONSEC;
        ST_NONSEC:  state_d = ST_NONSEC;
        ST_FAIL:    state_d = ST_FAIL;
        default:    state_d = ST_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             zmk_q <= '0;
    else if (viol_any || state_q == ST_FAIL) zmk_q <= '0;
    else if (zmk_load)                      zmk_q <= zmk_din;
  end

  assign key_valid = keys_open(state_q);
  assign otp_key_o = key_valid ? otp_key : '0;
  assign zmk_key_o = key_valid ? zmk_q : '0;
  assign sec_state = state_q;
  assign zeroize   = (state_q == ST_FAIL);

endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int unsigned CTR_W = 48,
  parameter int unsigned KEY_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             viol_any,
  input logic             boot_done,
  input logic             boot_pass,
  input logic             mc_inc,
  input logic [CTR_W-1:0] mc_value,
  input logic [KEY_W-1:0] otp_key_o,
  input logic [KEY_W-1:0] zmk_key_o,
  input logic [2:0]       sec_state,
  input logic             key_valid,
  input logic             zeroize
);
  p_init_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_state == 3'd0 && !viol_any && boot_done && boot_pass) |=> sec_state == 3'd1);

  p_keys_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> (otp_key_o == '0 && zmk_key_o == '0));

  p_key_not_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !zeroize);

  p_viol_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_any |=> sec_state == 3'd4);

  p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_state == 3'd4 |=> sec_state == 3'd4);

  p_ctr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_inc && !(&mc_value)) |=> mc_value == CTR_W'($past(mc_value) + CTR_W'(1)));

  p_ctr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_inc |=> $stable(mc_value));

  p_ctr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mc_value) |=> (&mc_value) && sec_state == 3'd4);
endmodule

bind tamper_state_monitor tsm_checker #(.CTR_W(CTR_W), .KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .viol_any  (viol_any),
  .boot_done (boot_done),
  .boot_pass (boot_pass),
  .mc_inc    (mc_inc),
  .mc_value  (mc_value),
  .otp_key_o (otp_key_o),
  .zmk_key_o (zmk_key_o),
  .sec_state (sec_state),
  .key_valid (key_valid),
  .zeroize   (zeroize)
);

// File: tb/tamper_state_monitor_test.sv
`timescale 1ns/1ps
module tamper_state_monitor_test;
  localparam int CW = 6;
  localparam logic [31:0] OTP  = 32'h5A5A1234;
  localparam logic [31:0] ZDAT = 32'hC0FFEE11;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_active;
  logic [9:0]  cfg_pol, pas_in, tin, tamper_out, tamper_oe;
  logic [3:0]  cfg_filt;
  logic [4:0]  flip;
  logic        sens_temp, sens_volt, sens_freq;
  logic        boot_done, boot_pass, lock_secure, drop_trust, mc_inc, zmk_load;
  logic [CW-1:0] mc_value;
  logic [31:0] zmk_din, otp_key_o, zmk_key_o;
  logic [2:0]  sec_state;
  logic        key_valid, zeroize;

  int total = 0, bad = 0;
  bit ended = 0;

  assign tin = cfg_active ? {tamper_out[4:0] ^ flip, 5'b0} : pas_in;

  tamper_state_monitor #(.CTR_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_pol(cfg_pol),
    .cfg_filt(cfg_filt), .tamper_in(tin), .tamper_out(tamper_out),
    .tamper_oe(tamper_oe), .sens_temp(sens_temp), .sens_volt(sens_volt),
    .sens_freq(sens_freq), .boot_done(boot_done), .boot_pass(boot_pass),
    .lock_secure(lock_secure), .drop_trust(drop_trust), .mc_inc(mc_inc),
    .mc_value(mc_value), .otp_key(OTP), .zmk_load(zmk_load), .zmk_din(zmk_din),
    .otp_key_o(otp_key_o), .zmk_key_o(zmk_key_o), .sec_state(sec_state),
    .key_valid(key_valid), .zeroize(zeroize)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit active);
    @(negedge clk);
    rst_n = 0; cfg_active = active; cfg_pol = 10'b0101010101; pas_in = 10'b0101010101;
    cfg_filt = 4'd3; flip = '0; sens_temp = 0; sens_volt = 0; sens_freq = 0;
    boot_done = 0; boot_pass = 0; lock_secure = 0; drop_trust = 0;
    mc_inc = 0; zmk_load = 0; zmk_din = '0;
    step(3);
    rst_n = 1;
    step(1);
  endtask

  task automatic to_trusted();
    boot_done = 1; boot_pass = 1; step(1); boot_done = 0; boot_pass = 0;
  endtask

  task automatic t_reset();
    do_reset(0);
    check("R1 state", sec_state, 0);
    check("R1 key_valid", key_valid, 0);
    check("R1 zeroize", zeroize, 0);
    check("R1 counter", mc_value, 0);
    check("R1 keys", {otp_key_o, zmk_key_o}, 0);
    check("R1 oe", tamper_oe, 0);
  endtask

  task automatic t_boot();
    do_reset(0);
    to_trusted();
    check("R2 boot pass->TRUSTED", sec_state, 1);
    lock_secure = 1; step(1); lock_secure = 0;
    check("R2 lock->SECURE", sec_state, 2);
    drop_trust = 1; step(1); drop_trust = 0;
    check("R2 drop->NON_SECURE", sec_state, 3);
    do_reset(0);
    boot_done = 1; boot_pass = 0; step(1); boot_done = 0;
    check("R2 boot fail->NON_SECURE", sec_state, 3);
  endtask

  task automatic t_keys();
    do_reset(0);
    to_trusted();
    zmk_din = ZDAT; zmk_load = 1; step(1); zmk_load = 0;
    check("R10 zmk visible", zmk_key_o, ZDAT);
    check("R3 otp released", otp_key_o, OTP);
    lock_secure = 1; step(1); lock_secure = 0;
    check("R3 key_valid in SECURE", key_valid, 1);
    drop_trust = 1; step(1); drop_trust = 0;
    check("R3 keys off in NON_SECURE", {otp_key_o, zmk_key_o, 31'b0, key_valid}, 0);
  endtask

  task automatic t_passive();
    do_reset(0);
    to_trusted();
    pas_in[7] = ~pas_in[7]; step(3); pas_in[7] = ~pas_in[7]; step(1);
    check("R6 filt edges not enough", sec_state, 1);
    pas_in[2] = ~pas_in[2]; step(3);
    check("R6 before threshold", sec_state, 1);
    step(1);
    check("R6 filt+1 edges -> FAIL", sec_state, 4);
    check("R4 zeroize in FAIL", zeroize, 1);
    check("R10 zmk cut after violation", zmk_key_o, 0);
    do_reset(0);
    to_trusted();
    cfg_filt = 4'd0; pas_in[0] = ~pas_in[0]; step(1);
    check("R6 zero filter immediate", sec_state, 4);
  endtask

  task automatic t_active();
    int changes = 0;
    logic [4:0] prev;
    do_reset(1);
    to_trusted();
    check("R7 oe pattern", tamper_oe, 10'h01F);
    prev = tamper_out[4:0];
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (tamper_out[4:0] != prev) changes++;
      prev = tamper_out[4:0];
    end
    check("R7 pattern changes", changes > 0, 1);
    check("R7 lower inputs ignored", sec_state, 1);
    flip[3] = 1; step(1); flip = '0; step(2);
    check("R7 single mismatch ignored", sec_state, 1);
    flip[3] = 1; step(2); flip = '0;
    check("R7 double mismatch -> FAIL", sec_state, 4);
  endtask

  task automatic t_sensor();
    for (int s = 0; s < 3; s++) begin
      do_reset(0);
      to_trusted();
      sens_temp = (s == 0); sens_volt = (s == 1); sens_freq = (s == 2);
      step(1);
      sens_temp = 0; sens_volt = 0; sens_freq = 0;
      check("R5 sensor -> FAIL", sec_state, 4);
    end
    boot_done = 1; boot_pass = 1; lock_secure = 1; drop_trust = 1; step(3);
    boot_done = 0; boot_pass = 0; lock_secure = 0; drop_trust = 0;
    check("R4 FAIL sticky", sec_state, 4);
    do_reset(0);
    check("R4 reset leaves FAIL", sec_state, 0);
    sens_volt = 1; step(1); sens_volt = 0;
    check("R4 violation from INIT", sec_state, 4);
  endtask

  task automatic t_counter();
    do_reset(0);
    to_trusted();
    mc_inc = 1; step(5); mc_inc = 0;
    check("R8 counter after 5", mc_value, 5);
    step(3);
    check("R8 counter holds", mc_value, 5);
    mc_inc = 1; step(58);
    check("R9 reached max", mc_value, 63);
    check("R9 not yet FAIL", sec_state, 1);
    step(1);
    check("R9 saturates", mc_value, 63);
    check("R9 rollover -> FAIL", sec_state, 4);
    mc_inc = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_boot();
    t_keys();
    t_passive();
    t_active();
    t_sensor();
    t_counter();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule